// File: doc/BRIEF.md
# Dual-Edge Strobe Host Receiver

This block takes commands and configuration bytes from a host over a three-wire link: a strobe, a mode flag and one data wire. Every transition of the strobe, rising or falling, carries one bit. The block collects eight such bits into a byte and hands it downstream with a one-cycle valid pulse. The byte is tagged as a command when the mode flag was high for its first bit, and as configuration data when it was low.

Flow control uses the acknowledge wire. After taking a bit, the receiver drives the acknowledge to the strobe level it just saw. The host may send the next bit only once the two levels match. A downstream ready input gates that update, so a busy consumer stalls the host. A second output reports a configuration status flag back to the host; it is a registered copy of a status input from the downstream controller.

All three host inputs cross into the system clock through two-flop synchronizers. A controller sets the mode and data wires, leaves them steady for at least two clocks, then toggles the strobe.

The receive state machine has two states. In `RX_LISTEN` it waits for a strobe transition. The transition "bit taken" moves it to `RX_STALL`. There the acknowledge is held until ready is high; the transition "ready seen" updates the acknowledge and returns to `RX_LISTEN`.

Top module: `strobe_byte_rx`

## Requirements
- R1: Reset drives host_ack, host_stat and rx_valid low, with the receiver in RX_LISTEN and no partial byte held.
- R2: Each synchronized strobe transition, rising or falling, captures exactly one bit. Eight captured bits form one byte, and the first bit received lands in rx_byte bit 0.
- R3: rx_valid is high for exactly one clock per completed byte and never without a completed byte.
- R4: rx_is_cmd equals the mode flag sampled with the first bit of the byte: 1 means command, 0 means configuration data.
- R5: After a bit is taken with rx_ready high, host_ack settles to the strobe level of that bit.
- R6: While rx_ready is low, host_ack does not change. Once rx_ready rises, host_ack takes the pending strobe level.
- R7: A bit whose mode flag differs from that of the partial byte in progress discards the partial byte and becomes bit 0 of a new byte. No rx_valid is produced for the discarded part.
- R8: host_stat equals cfg_status delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stb | input | 1 | Host strobe; each transition carries one bit |
| host_mode | input | 1 | 1 = command, 0 = configuration data |
| host_bit | input | 1 | Serial data bit |
| host_ack | output | 1 | Acknowledge, echoes the last taken strobe level |
| host_stat | output | 1 | Configuration status reported to the host |
| cfg_status | input | 1 | Status from the downstream controller |
| rx_ready | input | 1 | Downstream can accept more; gates the acknowledge |
| rx_valid | output | 1 | One-cycle pulse, rx_byte and rx_is_cmd valid |
| rx_byte | output | 8 | Assembled byte, first bit in bit 0 |
| rx_is_cmd | output | 1 | Tag of the byte: 1 command, 0 data |

## Verification
A wrong bit counter or shift direction shows at the ports on the very next rx_valid pulse. The byte is then rotated or mis-sized, or the pulse comes one strobe early or late, so the scoreboard finds it within one byte. A stuck state or a wrongly gated acknowledge shows within a few clocks of a strobe toggle: host_ack either fails to match the strobe, which stalls the host into a timeout, or moves while ready is low. A lost mode restart shows as an extra or mis-tagged byte at the end of the restarted sequence.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    typedef enum logic [0:0] {
        RX_LISTEN = 1'b0,
        RX_STALL  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sbr_status_reg.sv
module sbr_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_in,
    output logic stat_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_out <= 1'b0;
        else        stat_out <= stat_in;
    end
endmodule

// File: rtl/sbr_assemble.sv
module sbr_assemble
    import sbr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_lvl,
    input  logic              mode_in,
    input  logic              bit_in,
    input  logic              ready,
    output logic              ack,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_cmd
);
    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    rx_state_e         state_q, state_d;
    logic              stb_seen;
    logic              cur_mode;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              take;
    logic              restart;

    assign take    = (state_q == RX_LISTEN) && (stb_lvl != stb_seen);
    assign restart = (cnt != '0) && (mode_in != cur_mode);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_LISTEN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_LISTEN: if (take)  state_d = RX_STALL;   // bit taken
            RX_STALL:  if (ready) state_d = RX_LISTEN;  // ready seen
            default:              state_d = RX_LISTEN;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_seen  <= 1'b0;
            cur_mode  <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            ack       <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_cmd   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (take) begin
                stb_seen <= stb_lvl;
                if (cnt == '0 || restart) begin
                    cur_mode <= mode_in;
                    shreg    <= {bit_in, {(BYTE_W-1){1'b0}}};
                    cnt      <= CNT_W'(1);
                end else if (cnt == LAST_IDX) begin
                    out_byte  <= {bit_in, shreg[BYTE_W-1:1]};
                    out_cmd   <= cur_mode;
                    out_valid <= 1'b1;
                    cnt       <= '0;
                end else begin
                    shreg <= {bit_in, shreg[BYTE_W-1:1]};
                    cnt   <= cnt + CNT_W'(1);
                end
            end
            if (state_q == RX_STALL && ready) begin
                ack <= stb_seen;
            end
        end
    end
endmodule

// File: rtl/strobe_byte_rx.sv
module strobe_byte_rx #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_stb,
    input  logic              host_mode,
    input  logic              host_bit,
    output logic              host_ack,
    output logic              host_stat,
    input  logic              cfg_status,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_cmd
);
    logic [2:0] sync_vec;
    logic       stb_sync;
    logic       mode_sync;
    logic       bit_sync;

    sbr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_stb, host_mode, host_bit}),
        .sync_out (sync_vec)
    );

    assign {stb_sync, mode_sync, bit_sync} = sync_vec;

    sbr_assemble #(.BYTE_W(BYTE_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_lvl   (stb_sync),
        .mode_in   (mode_sync),
        .bit_in    (bit_sync),
        .ready     (rx_ready),
        .ack       (host_ack),
        .out_valid (rx_valid),
        .out_byte  (rx_byte),
        .out_cmd   (rx_is_cmd)
    );

    sbr_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_in  (cfg_status),
        .stat_out (host_stat)
    );
endmodule

// File: rtl/strobe_byte_rx_chk.sv
module strobe_byte_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic host_ack,
    input logic host_stat,
    input logic cfg_status,
    input logic rx_ready,
    input logic rx_valid,
    input logic stb_sync
);
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r6_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |=> $stable(host_ack));

    a_r5_ack_matches_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack != $past(host_ack)) |-> (host_ack == stb_sync));

    a_r8_stat_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (host_stat == $past(cfg_status)));

    a_r1_no_valid_in_reset: assert property (@(posedge clk)
        !rst_n |-> !rx_valid && !host_ack);
endmodule

bind strobe_byte_rx strobe_byte_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ack   (host_ack),
    .host_stat  (host_stat),
    .cfg_status (cfg_status),
    .rx_ready   (rx_ready),
    .rx_valid   (rx_valid),
    .stb_sync   (stb_sync)
);

// File: tb/sim_strobe_byte_rx.sv
module sim_strobe_byte_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_stb = 1'b0;
    logic       host_mode = 1'b0;
    logic       host_bit = 1'b0;
    logic       host_ack;
    logic       host_stat;
    logic       cfg_status = 1'b0;
    logic       rx_ready = 1'b1;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       rx_is_cmd;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q [$];
    logic       prev_valid = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    strobe_byte_rx u0 (
        .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_mode(host_mode),
        .host_bit(host_bit), .host_ack(host_ack), .host_stat(host_stat),
        .cfg_status(cfg_status), .rx_ready(rx_ready), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_is_cmd(rx_is_cmd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && prev_valid)
                check(1'b0, "R3 pulse longer than one cycle", 1, 0);
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R7 unexpected byte", {rx_is_cmd, rx_byte}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check(rx_byte == e[7:0], "R2 byte value", rx_byte, e[7:0]);
                    check(rx_is_cmd == e[8], "R4 command tag", rx_is_cmd, e[8]);
                end
            end
            prev_valid = rx_valid;
        end
    end

    task automatic send_bit(input logic b, input logic m);
        @(negedge clk);
        host_bit  = b;
        host_mode = m;
        repeat (2) @(negedge clk);
        host_stb = ~host_stb;
        begin
            int n;
            n = 0;
            while (host_ack != host_stb && n < 60) begin
                @(negedge clk);
                n++;
            end
            check(host_ack == host_stb, "R5 ack echoes strobe", host_ack, host_stb);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input logic m);
        exp_q.push_back({m, v});
        for (int i = 0; i < 8; i++) send_bit(v[i], m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(host_ack == 1'b0 && host_stat == 1'b0 && rx_valid == 1'b0,
              "R1 reset outputs", {host_ack, host_stat, rx_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4: data and command bytes, varied patterns
        send_byte(8'hA5, 1'b0);
        send_byte(8'h3C, 1'b1);
        send_byte(8'h01, 1'b0);
        send_byte(8'h80, 1'b1);
        send_byte(8'hFF, 1'b0);
        send_byte(8'h00, 1'b1);

        // R6: stall with ready low
        rx_ready = 1'b0;
        @(negedge clk);
        host_bit = 1'b1; host_mode = 1'b0;
        repeat (2) @(negedge clk);
        host_stb = ~host_stb;
        repeat (20) @(negedge clk);
        check(host_ack != host_stb, "R6 ack held while not ready", host_ack, ~host_stb);
        rx_ready = 1'b1;
        repeat (4) @(negedge clk);
        check(host_ack == host_stb, "R6 ack released after ready", host_ack, host_stb);
        // finish that byte: bit0=1 already sent
        exp_q.push_back({1'b0, 8'h6B});
        for (int i = 1; i < 8; i++) send_bit(1'(8'h6B >> i), 1'b0);

        // R7: partial data byte, then mode flips to command
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_byte(8'hC3, 1'b1);
        // R7: partial command byte, then data
        send_bit(1'b0, 1'b1);
        send_byte(8'h5A, 1'b0);

        // R8 status path
        @(negedge clk); cfg_status = 1'b1;
        @(negedge clk);
        check(host_stat == 1'b1, "R8 status follows", host_stat, 1);
        cfg_status = 1'b0;
        @(negedge clk);
        check(host_stat == 1'b0, "R8 status clears", host_stat, 0);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R3 every byte produced", exp_q.size(), 0);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule